// File: doc/BRIEF.md
# System Configuration Register Bank

This block is a bank of 32-bit control and status words in a 4 KB window on a simple peripheral bus. It holds eight general configuration slots, a clock-lock status word with a writable mask, and two read-only identification words. The identification word and the auxiliary identification word are parameters. An 8-bit part-number field inside the identification word selects the variant, and the variant decides which configuration slots exist. Slots that do not exist on a variant behave like unmapped space.

Two slots have side effects. On most variants, bit 0 of slot 0 drives a memory remap output, and the low bits of slot 1 drive a row of LED outputs. On one variant these two slots are plain storage and both outputs stay low. The lock status word combines a set of per-loop lock inputs under the mask and reports in bit 0 whether every loop that is watched is locked.

The bus has single-cycle read and write strobes and a 12-bit byte address. Address bits [1:0] are ignored. Read data is registered.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset the outputs hold these values. Read data is 0. Slot 0 holds the parameter `REG0_RST`. Slots 1, 2, 5, 6 and 7 hold 0. The lock mask is all ones. `remap_o` equals bit 0 of `REG0_RST`, except on the PART_C variant, where it is 0. `led_o` is 0.
- R2: A read strobe in cycle n loads `rdata_o` at the clock edge that ends cycle n. `rdata_o` keeps its value through every cycle that has no read strobe.
- R3: Slot 0 (byte offset 0x00) reads back the last word written to it. On every variant except PART_C, `remap_o` follows bit 0 of that word from the edge of the write. On PART_C, `remap_o` stays 0.
- R4: Slot 1 (offset 0x04) reads back the last word written to it. On every variant except PART_C, `led_o[i]` equals bit i of that word. On PART_C, `led_o` stays 0.
- R5: Slots 2 (0x08) and 5 (0x14) exist only when the part number (identification bits [11:4]) is PART_A, PART_B or PART_C. On those variants they read back what was written. On any other variant they read 0 and writes to them are ignored.
- R6: Slot 3 (0x0C) exists only on variants outside PART_A, PART_B and PART_C. It always reads 0 and ignores writes.
- R7: Slot 6 (0x18) exists only on PART_A and PART_C, and slot 7 (0x1C) exists only on PART_C. Each one is separate storage: a write to slot 7 leaves slot 6 unchanged.
- R8: Slot 4 (0x10) reads `REG4_VALUE`, offset 0xFF8 reads `AUXID_VALUE` and offset 0xFFC reads `ID_VALUE`. Writes to these three offsets change nothing.
- R9: The lock status word is at offset 0x100. Its bits [31:24] are the mask and the only writable field. Bits [23:16] show `lock_i` live. Bits [15:1] read 0.
- R10: Bit 0 of the lock status word is 1 exactly when every loop whose mask bit is 1 has its `lock_i` bit at 1. With an all-zero mask, bit 0 reads 1.
- R11: Any offset that is not listed, or that is absent on the variant, reads 0. A write to it changes no slot and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb_i | input | 1 | Single-cycle read strobe |
| wr_stb_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 12 | Byte offset in the window; bits [1:0] are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| lock_i | input | NUM_LOOPS | Per-loop lock flags |
| remap_o | output | 1 | Memory remap control (bit 0 of slot 0) |
| led_o | output | NUM_LEDS | LED drive (low bits of slot 1) |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle. They also assume that `lock_i` changes only between accesses, so the lock word that is read matches the inputs present at the strobe. The stimulus raises at most one strobe per access, always for exactly one cycle. It changes the lock inputs only while the bus is idle. Three copies of the block, one per variant class, receive the same bus traffic, so the presence rules for each variant are checked against the same sequence of accesses.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int NSLOT   = 8;
    localparam int FIELD_W = 8;

    localparam logic [WIDX_W-1:0] WIDX_LOCK  = 10'h040;
    localparam logic [WIDX_W-1:0] WIDX_AUXID = 10'h3FE;
    localparam logic [WIDX_W-1:0] WIDX_IDENT = 10'h3FF;

    // Values 0..7 must equal the slot number: the storage uses sel_e'(k).
    typedef enum logic [3:0] {
        SEL_CFG0  = 4'd0,
        SEL_CFG1  = 4'd1,
        SEL_CFG2  = 4'd2,
        SEL_CFG3  = 4'd3,
        SEL_CFG4  = 4'd4,
        SEL_CFG5  = 4'd5,
        SEL_CFG6  = 4'd6,
        SEL_CFG7  = 4'd7,
        SEL_LOCK  = 4'd8,
        SEL_AUXID = 4'd9,
        SEL_IDENT = 4'd10,
        SEL_NONE  = 4'd15
    } sel_e;

    function automatic sel_e widx_to_sel(input logic [WIDX_W-1:0] widx);
        sel_e s;
        if (widx < WIDX_W'(NSLOT)) s = sel_e'(widx[3:0]);
        else if (widx == WIDX_LOCK) s = SEL_LOCK;
        else if (widx == WIDX_AUXID) s = SEL_AUXID;
        else if (widx == WIDX_IDENT) s = SEL_IDENT;
        else s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter bit IN_FAMILY = 1'b1,
    parameter bit HAS_REG6  = 1'b1,
    parameter bit HAS_REG7  = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_e              sel_o
);

    sel_e raw;
    logic unused_lsb;

    assign unused_lsb = ^addr_i[1:0];

    always_comb begin
        raw   = widx_to_sel(addr_i[ADDR_W-1:2]);
        sel_o = raw;
        unique case (raw)
            SEL_CFG2, SEL_CFG5: if (!IN_FAMILY) sel_o = SEL_NONE;
            SEL_CFG3:           if (IN_FAMILY)  sel_o = SEL_NONE;
            SEL_CFG6:           if (!HAS_REG6)  sel_o = SEL_NONE;
            SEL_CFG7:           if (!HAS_REG7)  sel_o = SEL_NONE;
            default:            sel_o = raw;
        endcase
    end

endmodule

// File: rtl/sysctl_cfgstore.sv
module sysctl_cfgstore
    import sysctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] REG0_RST  = '0,
    parameter int                NUM_LEDS  = 8,
    parameter bit                IN_FAMILY = 1'b1,
    parameter bit                HAS_REG6  = 1'b1,
    parameter bit                HAS_REG7  = 1'b0,
    parameter bit                SIDE_OUTS = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  sel_e                          sel_i,
    input  logic [WORD_W-1:0]             wdata_i,
    output logic [NSLOT-1:0][WORD_W-1:0]  cfg_o,
    output logic                          remap_o,
    output logic [NUM_LEDS-1:0]           led_o
);

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        localparam bit KEEP = (k < 2)
                           || (((k == 2) || (k == 5)) && IN_FAMILY)
                           || ((k == 6) && HAS_REG6)
                           || ((k == 7) && HAS_REG7);
        localparam logic [WORD_W-1:0] RST_VAL = (k == 0) ? REG0_RST : '0;

        if (KEEP) begin : g_store
            logic wr_k;
            assign wr_k = wr_en_i && (sel_i == sel_e'(k));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     cfg_o[k] <= RST_VAL;
                else if (wr_k) cfg_o[k] <= wdata_i;
            end
        end else begin : g_absent
            assign cfg_o[k] = '0;
        end
    end

    if (SIDE_OUTS) begin : g_side
        assign remap_o = cfg_o[0][0];
        assign led_o   = cfg_o[1][NUM_LEDS-1:0];

        AST_REMAP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && sel_i == SEL_CFG0) |=> (remap_o == $past(wdata_i[0]))) // R3
            else $error("remap does not follow slot 0 bit 0");

        AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && sel_i == SEL_CFG1) |=> $stable(led_o)) // R4
            else $error("LEDs changed without a slot 1 write");
    end else begin : g_noside
        assign remap_o = 1'b0;
        assign led_o   = '0;
    end

endmodule

// File: rtl/sysctl_lockstat.sv
module sysctl_lockstat
    import sysctl_pkg::*;
#(
    parameter int NUM_LOOPS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [NUM_LOOPS-1:0] mask_wdata_i,
    input  logic [NUM_LOOPS-1:0] lock_i,
    output logic [WORD_W-1:0]    word_o
);

    localparam int PAD = FIELD_W - NUM_LOOPS;

    logic [NUM_LOOPS-1:0] mask_q;
    logic [FIELD_W-1:0]   mask_f;
    logic [FIELD_W-1:0]   flag_f;
    logic                 all_locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_en_i) mask_q <= mask_wdata_i;
    end

    if (PAD > 0) begin : g_pad
        assign mask_f = {{PAD{1'b1}}, mask_q};
        assign flag_f = {{PAD{1'b1}}, lock_i};
    end else begin : g_full
        assign mask_f = mask_q;
        assign flag_f = lock_i;
    end

    assign all_locked = &(lock_i | ~mask_q);
    assign word_o     = {mask_f, flag_f, 15'b0, all_locked};

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (word_o[31:24] == FIELD_W'({{PAD{1'b1}}, $past(mask_wdata_i)}))) // R9
        else $error("lock mask not loaded");

    AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&lock_i) |-> word_o[0]) // R10
        else $error("summary low while every loop locked");

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_VALUE    = 32'h4110_13A1,
    parameter logic [31:0] AUXID_VALUE = 32'hA1D0_000A,
    parameter logic [31:0] REG4_VALUE  = 32'h0000_4A4A,
    parameter logic [31:0] REG0_RST    = 32'h0000_0001,
    parameter logic [7:0]  PART_A      = 8'h3A,
    parameter logic [7:0]  PART_B      = 8'h4C,
    parameter logic [7:0]  PART_C      = 8'h5E,
    parameter int          NUM_LEDS    = 8,
    parameter int          NUM_LOOPS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_stb_i,
    input  logic                 wr_stb_i,
    input  logic [11:0]          addr_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    input  logic [NUM_LOOPS-1:0] lock_i,
    output logic                 remap_o,
    output logic [NUM_LEDS-1:0]  led_o
);

    localparam logic [7:0] PART      = ID_VALUE[11:4];
    localparam bit         IN_FAMILY = (PART == PART_A) || (PART == PART_B) || (PART == PART_C);
    localparam bit         HAS_REG6  = (PART == PART_A) || (PART == PART_C);
    localparam bit         HAS_REG7  = (PART == PART_C);
    localparam bit         SIDE_OUTS = (PART != PART_C);

    sel_e                         sel;
    logic [NSLOT-1:0][WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0]            lock_word;
    logic [WORD_W-1:0]            rd_word;

    sysctl_decode #(
        .IN_FAMILY (IN_FAMILY),
        .HAS_REG6  (HAS_REG6),
        .HAS_REG7  (HAS_REG7)
    ) u_decode (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    sysctl_cfgstore #(
        .REG0_RST  (REG0_RST),
        .NUM_LEDS  (NUM_LEDS),
        .IN_FAMILY (IN_FAMILY),
        .HAS_REG6  (HAS_REG6),
        .HAS_REG7  (HAS_REG7),
        .SIDE_OUTS (SIDE_OUTS)
    ) u_cfgstore (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_stb_i),
        .sel_i   (sel),
        .wdata_i (wdata_i),
        .cfg_o   (cfg_q),
        .remap_o (remap_o),
        .led_o   (led_o)
    );

    sysctl_lockstat #(
        .NUM_LOOPS (NUM_LOOPS)
    ) u_lockstat (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_stb_i && (sel == SEL_LOCK)),
        .mask_wdata_i (wdata_i[24 +: NUM_LOOPS]),
        .lock_i       (lock_i),
        .word_o       (lock_word)
    );

    always_comb begin
        unique case (sel)
            SEL_CFG0:  rd_word = cfg_q[0];
            SEL_CFG1:  rd_word = cfg_q[1];
            SEL_CFG2:  rd_word = cfg_q[2];
            SEL_CFG3:  rd_word = '0;
            SEL_CFG4:  rd_word = REG4_VALUE;
            SEL_CFG5:  rd_word = cfg_q[5];
            SEL_CFG6:  rd_word = cfg_q[6];
            SEL_CFG7:  rd_word = cfg_q[7];
            SEL_LOCK:  rd_word = lock_word;
            SEL_AUXID: rd_word = AUXID_VALUE;
            SEL_IDENT: rd_word = ID_VALUE;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_o <= '0;
        else if (rd_stb_i) rdata_o <= rd_word;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb_i && wr_stb_i)) // R2
        else $error("read and write strobes together");

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> $stable(rdata_o)) // R2
        else $error("read data moved without a read");

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && sel == SEL_NONE) |=> (rdata_o == '0)) // R11
        else $error("absent offset returned data");

    AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && sel == SEL_IDENT) |=> (rdata_o == ID_VALUE)) // R8
        else $error("identification word wrong");

endmodule

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;

    typedef struct {
        logic [31:0] ea;
        logic [31:0] ec;
        logic [31:0] eo;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  lock = 8'hFF;

    logic [31:0] rd_a, rd_c, rd_o;
    logic        rm_a, rm_c, rm_o;
    logic [7:0]  led_a, led_c, led_o;

    int   vectors = 0;
    int   miscompares = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    // Variant PART_A (defaults), variant PART_C, and a variant outside the family
    sysctl_regbank u_sysctl_regbank (
        .clk(clk), .rst_n(rst_n), .rd_stb_i(rd_stb), .wr_stb_i(wr_stb),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_a), .lock_i(lock),
        .remap_o(rm_a), .led_o(led_a));

    sysctl_regbank #(
        .ID_VALUE(32'h4110_15E2), .AUXID_VALUE(32'hA1D0_000C),
        .REG4_VALUE(32'h0000_4C4C)
    ) u_sysctl_regbank_c (
        .clk(clk), .rst_n(rst_n), .rd_stb_i(rd_stb), .wr_stb_i(wr_stb),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_c), .lock_i(lock),
        .remap_o(rm_c), .led_o(led_c));

    sysctl_regbank #(
        .ID_VALUE(32'h4110_1113), .AUXID_VALUE(32'hA1D0_0000),
        .REG4_VALUE(32'h0000_4040), .REG0_RST(32'h0000_0000)
    ) u_sysctl_regbank_o (
        .clk(clk), .rst_n(rst_n), .rd_stb_i(rd_stb), .wr_stb_i(wr_stb),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_o), .lock_i(lock),
        .remap_o(rm_o), .led_o(led_o));

    task automatic check(string tag, string who, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s [%s] actual %h expected %h", tag, who, act, exp);
        end
    endtask

    function automatic logic [31:0] lkw(logic [7:0] m, logic [7:0] l);
        return {m, l, 15'b0, &(l | ~m)};
    endfunction

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        wr_stb = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, logic [31:0] ea, logic [31:0] ec,
                            logic [31:0] eo, string tag);
        exp_t e;
        e.ea = ea; e.ec = ec; e.eo = eo; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        rd_stb = 1'b1; addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic check_side(string tag, logic ra, logic rc, logic ro,
                              logic [7:0] la, logic [7:0] lc, logic [7:0] lo);
        check(tag, "remap A", 32'(rm_a), 32'(ra));
        check(tag, "remap C", 32'(rm_c), 32'(rc));
        check(tag, "remap O", 32'(rm_o), 32'(ro));
        check(tag, "led A", 32'(led_a), 32'(la));
        check(tag, "led C", 32'(led_c), 32'(lc));
        check(tag, "led O", 32'(led_o), 32'(lo));
    endtask

    // Monitor: pops one expected item per read strobe seen at a rising edge
    initial begin
        forever begin
            logic seen;
            @(posedge clk);
            seen = rd_stb;
            @(negedge clk);
            if (seen) begin
                if (sb.size() == 0) begin
                    check("scoreboard", "queue", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, "A", rd_a, e.ea);
                    check(e.tag, "C", rd_c, e.ec);
                    check(e.tag, "O", rd_o, e.eo);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", "A", rd_a, 32'h0);
        check_side("R1 reset outputs", 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        rst_n = 1'b1;

        // R1 reset contents
        bus_read(12'h000, 32'h1, 32'h1, 32'h0, "R1 slot0 reset");
        bus_read(12'h004, 32'h0, 32'h0, 32'h0, "R1 slot1 reset");
        bus_read(12'h008, 32'h0, 32'h0, 32'h0, "R1 slot2 reset");
        bus_read(12'h018, 32'h0, 32'h0, 32'h0, "R1 slot6 reset");
        bus_read(12'h100, 32'hFFFF_0001, 32'hFFFF_0001, 32'hFFFF_0001, "R1 lock reset");

        // R3 remap
        bus_write(12'h000, 32'hA5A5_5A5A);
        check_side("R3 remap after even write", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        bus_read(12'h000, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 32'hA5A5_5A5A, "R3 slot0 readback");
        bus_write(12'h003, 32'h0000_0003);
        check_side("R3 remap after odd write", 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00);

        // R4 LEDs
        bus_write(12'h004, 32'h1234_56C3);
        check_side("R4 leds", 1'b1, 1'b0, 1'b1, 8'hC3, 8'h00, 8'hC3);
        bus_read(12'h004, 32'h1234_56C3, 32'h1234_56C3, 32'h1234_56C3, "R4 slot1 readback");

        // R2 hold: no strobe, data stays
        held = rd_a;
        @(negedge clk);
        @(negedge clk);
        check("R2 hold without strobe", "A", rd_a, held);
        bus_read(12'hFFC, 32'h4110_13A1, 32'h4110_15E2, 32'h4110_1113, "R2 R8 ident read");

        // R5 slots 2 and 5
        bus_write(12'h008, 32'hDEAD_0002);
        bus_write(12'h014, 32'h55AA_0005);
        bus_read(12'h008, 32'hDEAD_0002, 32'hDEAD_0002, 32'h0, "R5 slot2");
        bus_read(12'h014, 32'h55AA_0005, 32'h55AA_0005, 32'h0, "R5 slot5");

        // R6 slot 3
        bus_write(12'h00C, 32'hFFFF_FFFF);
        bus_read(12'h00C, 32'h0, 32'h0, 32'h0, "R6 slot3 reads zero");

        // R7 slots 6 and 7
        bus_write(12'h018, 32'h0000_0066);
        bus_write(12'h01C, 32'h0000_0077);
        bus_read(12'h018, 32'h66, 32'h66, 32'h0, "R7 slot6 untouched by slot7");
        bus_read(12'h01C, 32'h0, 32'h77, 32'h0, "R7 slot7");

        // R8 read-only words
        bus_write(12'h010, 32'h1111_1111);
        bus_write(12'hFF8, 32'h2222_2222);
        bus_write(12'hFFC, 32'h3333_3333);
        bus_read(12'h010, 32'h4A4A, 32'h4C4C, 32'h4040, "R8 slot4");
        bus_read(12'hFF8, 32'hA1D0_000A, 32'hA1D0_000C, 32'hA1D0_0000, "R8 auxid");
        bus_read(12'hFFC, 32'h4110_13A1, 32'h4110_15E2, 32'h4110_1113, "R8 ident after write");

        // R9 R10 lock word
        bus_write(12'h100, 32'h0F00_FFFF);
        bus_read(12'h100, lkw(8'h0F, 8'hFF), lkw(8'h0F, 8'hFF), lkw(8'h0F, 8'hFF), "R9 mask only");
        @(negedge clk); lock = 8'hF0;
        bus_read(12'h100, lkw(8'h0F, 8'hF0), lkw(8'h0F, 8'hF0), lkw(8'h0F, 8'hF0), "R10 unlocked watched");
        @(negedge clk); lock = 8'h0F;
        bus_read(12'h100, lkw(8'h0F, 8'h0F), lkw(8'h0F, 8'h0F), lkw(8'h0F, 8'h0F), "R10 watched locked");
        bus_write(12'h100, 32'h0000_0000);
        @(negedge clk); lock = 8'h00;
        bus_read(12'h100, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, "R10 empty mask");

        // R11 unmapped
        bus_write(12'h200, 32'hFFFF_FFFF);
        bus_write(12'h104, 32'hFFFF_FFFF);
        bus_read(12'h200, 32'h0, 32'h0, 32'h0, "R11 offset 0x200");
        bus_read(12'h0FC, 32'h0, 32'h0, 32'h0, "R11 offset 0x0FC");
        bus_read(12'h000, 32'h3, 32'h3, 32'h3, "R11 slot0 undisturbed");
        check_side("R11 outputs undisturbed", 1'b1, 1'b0, 1'b1, 8'hC3, 8'h00, 8'hC3);

        repeat (3) @(negedge clk);
        if (sb.size() != 0) check("scoreboard drain", "queue", 32'(sb.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule